// File: doc/BRIEF.md
# Transceiver Host Serial Port with Shared Byte Buffer

This block is the host-facing serial slave of a radio transceiver's digital controller. A microcontroller selects it with chip select, clocks bytes in and out on a serial clock, and uses one command byte per frame. The command lets the host fill or drain a shared transmit/receive byte buffer, write or read a bank of eight-bit control registers with an auto-incrementing address, or read a status byte. The radio side of the chip pushes received bytes into the same buffer and pops bytes to transmit through a simple strobe port. Register contents are presented in parallel to the rest of the controller, and each register write is signalled by a one-cycle strobe.

The serial pins are brought into the system clock domain through two-flop synchronisers. Clock polarity and phase are chosen by two static inputs, so all four common serial modes work. While the command byte is being shifted in, the output line returns the buffer's fill level. When the block is not selected, the output driver is released unless a receive pass-through mode is active. In that mode the demodulated data bit is driven straight to the output.

The control state machine has the states IDLE, CMD, BUF_RD, BUF_WR, STAT_RD, CTL_WADDR, CTL_WR, CTL_RADDR, CTL_RD and DISCARD. Dropping chip select in any state moves it to IDLE. IDLE moves to CMD once chip select is seen. At the end of the command byte, CMD moves to the state named by the opcode, or to DISCARD for an opcode it does not know. CTL_WADDR moves to CTL_WR after the address byte, and CTL_RADDR moves to CTL_RD after the address byte. BUF_RD, BUF_WR, STAT_RD, CTL_WR, CTL_RD and DISCARD stay where they are until chip select drops.

Top module: `xcvr_spi_slave`

## Requirements
- R1: Both data lines carry bytes most significant bit first. The slave samples the data input on the leading serial-clock edge when phase select is 0, and on the trailing edge when it is 1. The leading edge is the edge that leaves the idle level given by the polarity select. All four polarity/phase combinations give identical results.
- R2: During the command byte, the data output carries the number of bytes held in the buffer, zero-extended to eight bits.
- R3: Opcode bits [7:5] = 001 writes the following bytes into the buffer, and each stored byte adds one to the fill level. Opcode 000 returns buffer bytes in first-in first-out order, and each byte read removes one. A read from an empty buffer returns 0x00 and changes nothing. Radio push adds one byte, and radio pop removes the oldest byte.
- R4: In the buffer-write command, bits [4:0] give the largest number of bytes the frame may store, with 0 meaning no limit. Further bytes in that frame are dropped.
- R5: Opcode 011 takes a start-address byte and then data bytes that are written to consecutive control registers. Opcode 100 takes a start-address byte and then returns consecutive registers. The address wraps modulo the register count.
- R6: Bits [4:0] of the command byte have no effect for every opcode other than buffer write.
- R7: Opcode 010 returns the status byte: bit 7 is the supply-reset flag and bits [6:0] are the status inputs. The flag is 1 after reset and is set by a supply-low pulse. It is cleared when a status byte completes, so a second status byte in the same frame shows it as 0.
- R8: A control-register write while the transmit-active input is high empties the buffer. With that input low, the buffer is kept.
- R9: When chip select is low and pass-through is off, the output enable is 0. When pass-through is on with chip select low, the output enable is 1 and the output equals the pass-through data input.
- R10: Dropping chip select partway through a byte aborts that byte with no effect. The next frame starts with a fresh command byte.
- R11: A full buffer drops further writes, and the fill level never exceeds the buffer depth.
- R12: Opcodes 101, 110 and 111 make the rest of the frame inert: the output returns 0x00 and no register or buffer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs | input | 1 | Chip select, high = selected |
| spi_sck | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| sck_pol | input | 1 | Serial clock idle level |
| sck_pha | input | 1 | 0 = sample on leading edge, 1 = on trailing edge |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_en | output | 1 | Output driver enable, 0 = high impedance |
| xp_mode | input | 1 | Receive pass-through mode active |
| xp_data | input | 1 | Demodulated bit for pass-through |
| radio_push | input | 1 | Radio stores radio_wdata into the buffer |
| radio_wdata | input | 8 | Byte from the receiver |
| radio_pop | input | 1 | Radio removes the oldest buffer byte |
| radio_rdata | output | 8 | Oldest buffer byte |
| radio_avail | output | 1 | Buffer not empty |
| tx_active | input | 1 | Transmitter is in transmit mode |
| stat_in | input | 7 | Live status bits |
| supply_low | input | 1 | Supply-dip event, sets the reset flag |
| ctl_wr_stb | output | 1 | One-cycle strobe per control-register write |
| ctl_wr_addr | output | $clog2(NUM_CTL) | Address being written |
| ctl_regs | output | NUM_CTL*8 | All control registers, register n in bits [8n+7:8n] |

## Verification
Serial pins pass through two synchroniser flops and an edge detector, so a sampled bit acts about three system clocks after its serial-clock edge. Buffer, register and flag updates land on the clock edge that completes the byte. The output bit changes about three clocks after the slave's sampling edge, and the bench reads it half a serial period later, just before the host's own sampling edge, matching what a real host sees. Radio strobes and register contents are read at the falling system-clock edge after the rising edge that registers them. Fill levels and flags are observed through later command or status bytes, so every expected value is one a host would actually receive.

// File: rtl/xcvr_spi_pkg.sv
package xcvr_spi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_BUF_RD,
        ST_BUF_WR,
        ST_STAT_RD,
        ST_CTL_WADDR,
        ST_CTL_WR,
        ST_CTL_RADDR,
        ST_CTL_RD,
        ST_DISCARD
    } spi_state_e;

    localparam logic [2:0] OP_BUF_RD  = 3'b000;
    localparam logic [2:0] OP_BUF_WR  = 3'b001;
    localparam logic [2:0] OP_STAT_RD = 3'b010;
    localparam logic [2:0] OP_CTL_WR  = 3'b011;
    localparam logic [2:0] OP_CTL_RD  = 3'b100;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs,
    input  logic sdi,
    input  logic cpol,
    input  logic cpha,
    output logic cs_on,
    output logic sdi_s,
    output logic smp_evt
);
    logic [2:0] sck_sh;
    logic [1:0] cs_sh;
    logic [1:0] sdi_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sh <= '0;
            cs_sh  <= '0;
            sdi_sh <= '0;
        end else begin
            sck_sh <= {sck_sh[1:0], sck};
            cs_sh  <= {cs_sh[0], cs};
            sdi_sh <= {sdi_sh[0], sdi};
        end
    end

    assign cs_on   = cs_sh[1];
    assign sdi_s   = sdi_sh[1];
    // sampling edge: leading (to ~cpol) for cpha=0, trailing (to cpol) for cpha=1
    assign smp_evt = cs_on && (sck_sh[2] != sck_sh[1]) && (sck_sh[1] == (cpol ^ ~cpha));
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/spi_ctl_file.sv
module spi_ctl_file #(
    parameter int NREG = 8,
    parameter int W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] addr,
    input  logic [W-1:0]            wdata,
    output logic [W-1:0]            rdata,
    output logic [NREG*W-1:0]       regs_flat
);
    localparam int RAW = $clog2(NREG);

    logic [W-1:0] r [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      r[g] <= '0;
            else if (we && addr == RAW'(g))  r[g] <= wdata;
        end
        assign regs_flat[g*W +: W] = r[g];
    end

    assign rdata = r[addr];
endmodule

// File: rtl/xcvr_spi_slave.sv
module xcvr_spi_slave #(
    parameter int BUF_DEPTH = 16,
    parameter int NUM_CTL   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_cs,
    input  logic                        spi_sck,
    input  logic                        spi_sdi,
    input  logic                        sck_pol,
    input  logic                        sck_pha,
    output logic                        spi_sdo,
    output logic                        spi_sdo_en,
    input  logic                        xp_mode,
    input  logic                        xp_data,
    input  logic                        radio_push,
    input  logic [7:0]                  radio_wdata,
    input  logic                        radio_pop,
    output logic [7:0]                  radio_rdata,
    output logic                        radio_avail,
    input  logic                        tx_active,
    input  logic [6:0]                  stat_in,
    input  logic                        supply_low,
    output logic                        ctl_wr_stb,
    output logic [$clog2(NUM_CTL)-1:0]  ctl_wr_addr,
    output logic [NUM_CTL*8-1:0]        ctl_regs
);
    import xcvr_spi_pkg::*;

    localparam int CNT_W = $clog2(BUF_DEPTH+1);
    localparam int CA_W  = $clog2(NUM_CTL);

    logic              cs_on, sdi_s, smp_evt;
    spi_state_e        state_q, state_d;
    logic [2:0]        bit_q;
    logic [6:0]        shin_q;
    logic [4:0]        wr_lim_q, wr_cnt_q;
    logic [CA_W-1:0]   ptr_q;
    logic              dvcc_flag_q;
    logic              spi_push, spi_pop, ctl_we, buf_clr;
    logic [7:0]        tx_byte, ctl_rdata, buf_head;
    logic [CNT_W-1:0]  buf_count;
    logic              buf_empty, buf_full;
    logic              byte_done, stat_byte_end;
    logic [7:0]        rx_byte;

    spi_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs(spi_cs), .sdi(spi_sdi),
        .cpol(sck_pol), .cpha(sck_pha),
        .cs_on(cs_on), .sdi_s(sdi_s), .smp_evt(smp_evt)
    );

    assign byte_done     = smp_evt && (bit_q == 3'd7);
    assign rx_byte       = {shin_q, sdi_s};
    assign stat_byte_end = byte_done && (state_q == ST_STAT_RD);

    // bit counter and input shifter; cleared whenever the frame is closed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            shin_q <= '0;
        end else if (!cs_on) begin
            bit_q  <= '0;
        end else if (smp_evt) begin
            bit_q  <= bit_q + 3'd1;
            shin_q <= {shin_q[5:0], sdi_s};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs_on) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        unique case (rx_byte[7:5])
                            OP_BUF_RD:  state_d = ST_BUF_RD;
                            OP_BUF_WR:  state_d = ST_BUF_WR;
                            OP_STAT_RD: state_d = ST_STAT_RD;
                            OP_CTL_WR:  state_d = ST_CTL_WADDR;
                            OP_CTL_RD:  state_d = ST_CTL_RADDR;
                            default:    state_d = ST_DISCARD;
                        endcase
                    end
                end
                ST_CTL_WADDR: if (byte_done) state_d = ST_CTL_WR;
                ST_CTL_RADDR: if (byte_done) state_d = ST_CTL_RD;
                default:      state_d = state_q;
            endcase
        end
    end

    // per-state outputs: strobes and the byte presented on the output line
    always_comb begin
        spi_push = 1'b0;
        spi_pop  = 1'b0;
        ctl_we   = 1'b0;
        tx_byte  = '0;
        unique case (state_q)
            ST_CMD:     tx_byte = 8'(buf_count);
            ST_BUF_RD: begin
                tx_byte = buf_empty ? 8'h00 : buf_head;
                spi_pop = byte_done;
            end
            ST_BUF_WR:  spi_push = byte_done && ((wr_lim_q == '0) || (wr_cnt_q < wr_lim_q));
            ST_STAT_RD: tx_byte = {dvcc_flag_q, stat_in};
            ST_CTL_WR:  ctl_we = byte_done;
            ST_CTL_RD:  tx_byte = ctl_rdata;
            default:    tx_byte = '0;
        endcase
    end

    // command fields, address pointer and supply-reset flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_lim_q    <= '0;
            wr_cnt_q    <= '0;
            ptr_q       <= '0;
            dvcc_flag_q <= 1'b1;
        end else begin
            if (supply_low)         dvcc_flag_q <= 1'b1;
            else if (stat_byte_end) dvcc_flag_q <= 1'b0;
            if (state_q == ST_CMD && byte_done) begin
                wr_lim_q <= rx_byte[4:0];
                wr_cnt_q <= '0;
            end else if (spi_push) begin
                wr_cnt_q <= wr_cnt_q + 5'd1;
            end
            if ((state_q == ST_CTL_WADDR || state_q == ST_CTL_RADDR) && byte_done)
                ptr_q <= rx_byte[CA_W-1:0];
            else if (ctl_we || (state_q == ST_CTL_RD && byte_done))
                ptr_q <= ptr_q + 1'b1;
        end
    end

    assign buf_clr = ctl_we && tx_active;

    spi_byte_fifo #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .push(spi_push || radio_push),
        .din(spi_push ? rx_byte : radio_wdata),
        .pop(spi_pop || radio_pop),
        .dout(buf_head), .count(buf_count), .empty(buf_empty), .full(buf_full)
    );

    spi_ctl_file #(.NREG(NUM_CTL), .W(8)) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .addr(ptr_q), .wdata(rx_byte),
        .rdata(ctl_rdata), .regs_flat(ctl_regs)
    );

    assign radio_rdata = buf_head;
    assign radio_avail = !buf_empty;
    assign ctl_wr_stb  = ctl_we;
    assign ctl_wr_addr = ptr_q;
    assign spi_sdo_en  = cs_on || xp_mode;
    assign spi_sdo     = cs_on ? tx_byte[3'd7 - bit_q] : (xp_mode && xp_data);
endmodule

// File: rtl/xcvr_spi_chk.sv
module xcvr_spi_chk #(
    parameter int BUF_DEPTH = 16,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs,
    input logic             xp_mode,
    input logic             spi_sdo_en,
    input logic             cs_on,
    input logic [2:0]       bit_q,
    input logic [CNT_W-1:0] buf_count,
    input logic             ctl_wr_stb,
    input logic             tx_active,
    input logic             stat_byte_end,
    input logic             supply_low,
    input logic             dvcc_flag_q
);
    AST_SDO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs && !$past(spi_cs) && !$past(spi_cs, 2) && !xp_mode) |-> !spi_sdo_en); // R9

    AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= CNT_W'(BUF_DEPTH)); // R11

    AST_TXW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_stb && tx_active) |=> (buf_count == '0)); // R8

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte_end && !supply_low) |=> !dvcc_flag_q); // R7

    AST_ABORT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_on |=> (bit_q == 3'd0)); // R10

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_wr_stb && tx_active) |->
            ((buf_count == $past(buf_count)) ||
             (buf_count == $past(buf_count) + CNT_W'(1)) ||
             (buf_count + CNT_W'(1) == $past(buf_count)))); // R3
endmodule

bind xcvr_spi_slave xcvr_spi_chk #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .xp_mode(xp_mode),
    .spi_sdo_en(spi_sdo_en), .cs_on(cs_on), .bit_q(bit_q), .buf_count(buf_count),
    .ctl_wr_stb(ctl_wr_stb), .tx_active(tx_active), .stat_byte_end(stat_byte_end),
    .supply_low(supply_low), .dvcc_flag_q(dvcc_flag_q)
);

// File: tb/test_xcvr_spi_slave.sv
module test_xcvr_spi_slave;
    localparam time H = 40ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_cs = 0, spi_sck = 0, spi_sdi = 0, sck_pol = 0, sck_pha = 0;
    logic spi_sdo, spi_sdo_en;
    logic xp_mode = 0, xp_data = 0;
    logic radio_push = 0, radio_pop = 0;
    logic [7:0] radio_wdata = 0, radio_rdata;
    logic radio_avail, tx_active = 0, supply_low = 0;
    logic [6:0] stat_in = 7'h35;
    logic ctl_wr_stb;
    logic [2:0] ctl_wr_addr;
    logic [63:0] ctl_regs;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] got;
    event byte_ev;
    bit    chk_q[$];
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #2.5ns clk = ~clk;

    xcvr_spi_slave i_xcvr_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
        .sck_pol(sck_pol), .sck_pha(sck_pha), .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en),
        .xp_mode(xp_mode), .xp_data(xp_data), .radio_push(radio_push),
        .radio_wdata(radio_wdata), .radio_pop(radio_pop), .radio_rdata(radio_rdata),
        .radio_avail(radio_avail), .tx_active(tx_active), .stat_in(stat_in),
        .supply_low(supply_low), .ctl_wr_stb(ctl_wr_stb), .ctl_wr_addr(ctl_wr_addr),
        .ctl_regs(ctl_regs)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: compares each completed byte against the queued expectation
    initial forever begin
        @(byte_ev);
        if (exp_q.size() > 0) begin
            bit c = chk_q.pop_front();
            logic [7:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            if (c) check(t, "sdo byte", {24'h0, got}, {24'h0, e});
        end
    end

    task automatic xfer(input logic [7:0] d, input logic [7:0] e, input bit c, input string tag);
        logic [7:0] g;
        chk_q.push_back(c); exp_q.push_back(e); tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            if (!sck_pha) begin
                spi_sdi = d[i]; #(H); g[i] = spi_sdo; spi_sck = ~sck_pol; #(H); spi_sck = sck_pol;
            end else begin
                spi_sck = ~sck_pol; spi_sdi = d[i]; #(H); g[i] = spi_sdo; spi_sck = sck_pol; #(H);
            end
        end
        got = g;
        ->byte_ev;
    endtask

    task automatic fbeg(); spi_cs = 1; #(H); endtask
    task automatic fend(); #(H); spi_cs = 0; #(4*H); endtask

    task automatic set_mode(input logic p, input logic h);
        sck_pol = p; sck_pha = h; spi_sck = p; #(4*H);
    endtask

    // probe the fill level through a status frame
    task automatic probe_count(input logic [7:0] exp_cnt, input string tag);
        fbeg(); xfer(8'h40, exp_cnt, 1, tag); fend();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            #(H);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #750us;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check("R9", "sdo_en after reset", {31'h0, spi_sdo_en}, 0);
        check("R5", "regs after reset", ctl_regs[31:0], 0);
        check("R3", "avail after reset", {31'h0, radio_avail}, 0);

        // R7 status: flag set from reset, cleared after first status byte
        fbeg();
        xfer(8'h40, 8'h00, 1, "R2 count empty");
        xfer(8'h00, 8'hB5, 1, "R7 flag set");
        xfer(8'h00, 8'h35, 1, "R7 flag cleared");
        fend();

        // R3 buffer write/read in order
        fbeg(); xfer(8'h20, 8'h00, 1, "R2"); xfer(8'hA1,0,0,""); xfer(8'hB2,0,0,""); xfer(8'hC3,0,0,""); fend();
        fbeg();
        xfer(8'h00, 8'h03, 1, "R2 count three");
        xfer(8'h00, 8'hA1, 1, "R3 fifo 1");
        xfer(8'h00, 8'hB2, 1, "R3 fifo 2");
        xfer(8'h00, 8'hC3, 1, "R3 fifo 3");
        xfer(8'h00, 8'h00, 1, "R3 empty read");
        fend();
        probe_count(8'h00, "R3 drained");

        // R4 write limit of two
        fbeg(); xfer(8'h22, 8'h00, 1, "R2"); xfer(8'h11,0,0,""); xfer(8'h22,0,0,""); xfer(8'h33,0,0,""); fend();
        fbeg();
        xfer(8'h00, 8'h02, 1, "R4 limited count");
        xfer(8'h00, 8'h11, 1, "R4 byte 1");
        xfer(8'h00, 8'h22, 1, "R4 byte 2");
        xfer(8'h00, 8'h00, 1, "R4 third dropped");
        fend();

        // R3 radio side
        @(negedge clk); radio_wdata = 8'h5A; radio_push = 1;
        @(negedge clk); radio_push = 0;
        check("R3", "radio avail", {31'h0, radio_avail}, 1);
        check("R3", "radio head", {24'h0, radio_rdata}, 8'h5A);
        probe_count(8'h01, "R3 radio push count");
        @(negedge clk); radio_pop = 1;
        @(negedge clk); radio_pop = 0;
        check("R3", "radio avail after pop", {31'h0, radio_avail}, 0);

        // R5 control write with wrap, then read back
        fbeg(); xfer(8'h60, 0, 0, ""); xfer(8'h06, 0, 0, "");
        xfer(8'hD0,0,0,""); xfer(8'hD1,0,0,""); xfer(8'hD2,0,0,""); fend();
        check("R5", "reg6", {24'h0, ctl_regs[48 +: 8]}, 8'hD0);
        check("R5", "reg7", {24'h0, ctl_regs[56 +: 8]}, 8'hD1);
        check("R5", "reg0 wrap", {24'h0, ctl_regs[0 +: 8]}, 8'hD2);
        fbeg(); xfer(8'h80, 0, 0, ""); xfer(8'h06, 0, 0, "");
        xfer(8'h00, 8'hD0, 1, "R5 read 6"); xfer(8'h00, 8'hD1, 1, "R5 read 7");
        xfer(8'h00, 8'hD2, 1, "R5 read wrap"); fend();

        // R6 low command bits ignored
        fbeg(); xfer(8'h7F, 0, 0, ""); xfer(8'h01, 0, 0, ""); xfer(8'h44, 0, 0, ""); fend();
        check("R6", "reg1 via 0x7F", {24'h0, ctl_regs[8 +: 8]}, 8'h44);
        fbeg(); xfer(8'h5F, 8'h00, 1, "R6 count"); xfer(8'h00, 8'h35, 1, "R6 status via 0x5F"); fend();

        // R7 supply-low sets flag again
        @(negedge clk); supply_low = 1; @(negedge clk); supply_low = 0;
        fbeg(); xfer(8'h40, 8'h00, 1, "R2"); xfer(8'h00, 8'hB5, 1, "R7 flag reset by supply");
        xfer(8'h00, 8'h35, 1, "R7 cleared again"); fend();

        // R8 control write keeps buffer unless transmitting
        fbeg(); xfer(8'h20, 0, 0, ""); xfer(8'h01,0,0,""); xfer(8'h02,0,0,""); fend();
        fbeg(); xfer(8'h60, 0, 0, ""); xfer(8'h02, 0, 0, ""); xfer(8'h77, 0, 0, ""); fend();
        probe_count(8'h02, "R8 kept when idle");
        tx_active = 1;
        fbeg(); xfer(8'h60, 0, 0, ""); xfer(8'h02, 0, 0, ""); xfer(8'h78, 0, 0, ""); fend();
        tx_active = 0;
        probe_count(8'h00, "R8 cleared in tx");

        // R12 unknown opcode is inert
        fbeg(); xfer(8'hE0, 8'h00, 1, "R2"); xfer(8'h20, 8'h00, 1, "R12 sdo zero");
        xfer(8'h55, 8'h00, 1, "R12 sdo zero 2"); fend();
        probe_count(8'h00, "R12 buffer untouched");
        check("R12", "reg2 untouched", {24'h0, ctl_regs[16 +: 8]}, 8'h78);

        // R10 abort mid-byte, then a clean frame
        spi_cs = 1; #(H);
        for (int i = 0; i < 4; i++) begin
            spi_sdi = 1'b1; #(H); spi_sck = 1; #(H); spi_sck = 0;
        end
        #(H); spi_cs = 0; #(4*H);
        fbeg(); xfer(8'h20, 8'h00, 1, "R10 fresh command"); xfer(8'h9C, 0, 0, ""); fend();
        fbeg(); xfer(8'h00, 8'h01, 1, "R10 count"); xfer(8'h00, 8'h9C, 1, "R10 data"); fend();

        // R11 overfill
        fbeg(); xfer(8'h20, 0, 0, "");
        for (int i = 0; i < 20; i++) xfer(8'(i + 8'h30), 0, 0, "");
        fend();
        fbeg(); xfer(8'h00, 8'h10, 1, "R11 full count"); xfer(8'h00, 8'h30, 1, "R11 first kept"); fend();
        probe_count(8'h0F, "R11 after one read");
        tx_active = 1;
        fbeg(); xfer(8'h60, 0, 0, ""); xfer(8'h03, 0, 0, ""); xfer(8'h00, 0, 0, ""); fend();
        tx_active = 0;

        // R1 all four serial modes
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            fbeg(); xfer(8'h60, 0, 0, ""); xfer(8'h04, 0, 0, ""); xfer(8'(8'hC5 ^ m), 0, 0, ""); fend();
            fbeg(); xfer(8'h80, 8'h00, 1, "R1 count"); xfer(8'h04, 0, 0, "");
            xfer(8'h00, 8'(8'hC5 ^ m), 1, "R1 mode readback"); fend();
            fbeg(); xfer(8'h40, 8'h00, 1, "R1 cmd"); xfer(8'h00, 8'h35, 1, "R1 status"); fend();
        end
        set_mode(0, 0);

        // R9 pass-through and release
        xp_mode = 1; xp_data = 1;
        repeat (3) @(negedge clk);
        check("R9", "xp enable", {31'h0, spi_sdo_en}, 1);
        check("R9", "xp data 1", {31'h0, spi_sdo}, 1);
        xp_data = 0; @(negedge clk);
        check("R9", "xp data 0", {31'h0, spi_sdo}, 0);
        xp_mode = 0; @(negedge clk);
        check("R9", "released", {31'h0, spi_sdo_en}, 0);

        finish_up();
    end
endmodule